// File: doc/BRIEF.md
# Chainable SPI Register Slave

This block is a serial register slave that sits on an SPI bus where several slaves share one active-low chip select and are wired in a ring: each slave's serial output feeds the next slave's serial input. Bits entering on the data input move through a 16-bit shift register and leave on the data output. A frame that is not meant for this slave therefore travels on to its neighbour. While chip select is low, the block only shifts. It decodes the last 16 bits it holds only when chip select returns high, and only if the transfer was long enough and whole in bytes.

A frame carries a write flag, a 7-bit address and 8 data bits. A write updates the addressed entry of a small register file. A read schedules that entry's content as the word this slave shifts out during the next transfer. Every other frame leaves a status word queued. The status word has a flag that reports a rejected transfer. The serial pins are sampled by the system clock through synchronizers. The serial clock must therefore run several times slower than the system clock.

Top module: `spi_chain_slave`

## Requirements
- R1: While chip select is high, `spi_miso` and `spi_miso_oe` are both 0. This holds from reset onward.
- R2: Bits are captured on the rising serial clock edge and shifted on the falling edge, MSB first. A bit that enters on `spi_mosi` leaves on `spi_miso` 16 serial clocks later.
- R3: A frame is accepted only at the rise of chip select. An accepted frame with bit 15 = 1 writes bits 7:0 into the register addressed by bits 14:8.
- R4: An accepted frame with bit 15 = 0 is a read. During the next transfer, the first 16 bits shifted out are {1'b0, address[6:0], data[7:0]}.
- R5: After an accepted write, the next transfer returns the status word 16'h8000: bit 15 = 1, bit 8 = 0 (no error), all other bits 0. The same word is queued after reset.
- R6: A transfer whose bit count is not a multiple of 8, or is below 16, is discarded and does not change the registers. The next transfer then returns 16'h8100, which is the status word with the error bit 8 set.
- R7: A transfer of any multiple of 8 bits from 16 upward is accepted. Its last 16 bits form the frame. The bits beyond the first 16 that are shifted out are the earliest bits shifted in.
- R8: A write to an address at or above NREGS is ignored and does not alias onto a lower register. A read of such an address returns data 0.
- R9: After a discarded transfer, the next accepted frame again sets the reply by R4 or R5. The error flag does not persist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select shared by the chain |
| spi_mosi | input | 1 | Serial data input |
| spi_miso | output | 1 | Serial data output, 0 while deselected |
| spi_miso_oe | output | 1 | Output enable for an external tri-state buffer |

## Verification
The bench builds the block with NREGS = 6. A register count that is not a power of two puts addresses 6 and 7 inside the index range but outside the file. This is the case where a missing range check would write past the end or alias. An address of 0x41 is used to test for aliasing onto register 1. Frame size and byte granularity stay at 16 and 8. This allows 8-, 12-, 20-, 24- and 32-bit transfers that cover rejected, short, unaligned and chained cases, with two synchronizer stages.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int FW = 16;
  localparam int AW = 7;
  localparam int DW = 8;

  localparam logic [FW-1:0] ST_OK   = 16'h8000;
  localparam logic [FW-1:0] ST_FERR = 16'h8100;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } frame_t;

  function automatic logic [FW-1:0] read_reply(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {1'b0, a, d};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_active,
  output logic mosi_s
);
  localparam logic [2:0] IDLE = 3'b010;  // {sclk, cs_n, mosi}

  logic [2:0] pipe [STAGES];
  logic [2:0] last;
  logic [2:0] cur;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= IDLE;
        else     pipe[0] <= {sclk, cs_n, mosi};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= IDLE;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign cur = pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last <= IDLE;
    else     last <= cur;
  end

  assign sclk_rise = cur[2] & ~last[2];
  assign sclk_fall = ~cur[2] & last[2];
  assign cs_fall   = ~cur[1] & last[1];
  assign cs_rise   = cur[1] & ~last[1];
  assign cs_active = ~cur[1];
  assign mosi_s    = cur[0];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int FW   = 16,
  parameter int GRAN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          cs_active,
  input  logic          mosi_s,
  input  logic [FW-1:0] load_word,
  output logic [FW-1:0] shreg,
  output logic          frame_done,
  output logic          frame_ok,
  output logic          miso,
  output logic          miso_oe
);
  localparam int UNITS = FW / GRAN;
  localparam int CW    = (GRAN > 1) ? $clog2(GRAN) : 1;
  localparam int UW    = $clog2(UNITS + 1);

  logic          rx_bit;
  logic [CW-1:0] bit_cnt;
  logic [UW-1:0] unit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      rx_bit     <= 1'b0;
      bit_cnt    <= '0;
      unit_cnt   <= '0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      miso       <= 1'b0;
      miso_oe    <= 1'b0;
    end else begin
      frame_done <= cs_rise;
      frame_ok   <= (bit_cnt == '0) && (unit_cnt == UW'(UNITS));
      miso_oe    <= cs_active;
      miso       <= cs_active & shreg[FW-1];
      if (cs_fall) begin
        shreg    <= load_word;
        bit_cnt  <= '0;
        unit_cnt <= '0;
      end else if (cs_active) begin
        if (sclk_rise) rx_bit <= mosi_s;
        if (sclk_fall) begin
          shreg <= {shreg[FW-2:0], rx_bit};
          if (bit_cnt == CW'(GRAN - 1)) begin
            bit_cnt <= '0;
            if (unit_cnt != UW'(UNITS)) unit_cnt <= unit_cnt + 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_chain_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_done,
  input  logic          frame_ok,
  input  logic [FW-1:0] frame,
  input  logic [DW-1:0] rd_data,
  output logic          we,
  output logic [IW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic [IW-1:0] raddr,
  output logic [FW-1:0] resp
);
  frame_t f;
  logic   addr_ok;

  assign f       = frame_t'(frame);
  assign addr_ok = int'(f.addr) < NREGS;
  assign raddr   = f.addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
      resp  <= ST_OK;
    end else begin
      we <= 1'b0;
      if (frame_done) begin
        if (!frame_ok) begin
          resp <= ST_FERR;
        end else if (f.wr) begin
          resp  <= ST_OK;
          we    <= addr_ok;
          waddr <= f.addr[IW-1:0];
          wdata <= f.data;
        end else begin
          resp <= read_reply(f.addr, addr_ok ? rd_data : '0);
        end
      end
    end
  end
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave #(
  parameter int NREGS       = 8,
  parameter int GRAN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  import spi_chain_pkg::*;

  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic          sclk_rise, sclk_fall, cs_fall, cs_rise, cs_active, mosi_s;
  logic [FW-1:0] shreg, resp;
  logic          frame_done, frame_ok;
  logic          we;
  logic [IW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rd_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_active(cs_active), .mosi_s(mosi_s)
  );

  spi_frame_shifter #(.FW(FW), .GRAN(GRAN)) u_shift (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_active(cs_active), .mosi_s(mosi_s),
    .load_word(resp), .shreg(shreg), .frame_done(frame_done), .frame_ok(frame_ok),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_cmd_decoder #(.NREGS(NREGS), .IW(IW)) u_dec (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_ok(frame_ok),
    .frame(shreg), .rd_data(rd_data), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .resp(resp)
  );

  spi_reg_bank #(.DEPTH(NREGS), .DW(DW), .IW(IW)) u_bank (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int FW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          spi_cs_n,
  input logic          spi_miso,
  input logic          spi_miso_oe,
  input logic          cs_fall,
  input logic          sclk_fall,
  input logic [FW-1:0] shreg,
  input logic [FW-1:0] resp,
  input logic          frame_done,
  input logic          frame_ok,
  input logic          we
);
  logic [3:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)                hi_run <= '0;
    else if (!spi_cs_n)     hi_run <= '0;
    else if (hi_run != 4'hF) hi_run <= hi_run + 1'b1;
  end

  // R1: output quiet once deselect has passed the synchronizer
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (int'(hi_run) > SYNC_STAGES + 1) |-> (!spi_miso_oe && !spi_miso));

  // R2: shift register moves only on a serial falling edge or a select load
  a_r2_shift_hold: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !cs_fall) |=> $stable(shreg));

  // R4: pending reply is loaded at select
  a_r4_load_reply: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (shreg == $past(resp)));

  // R3: register writes only follow an accepted frame
  a_r3_write_on_commit: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(frame_done && frame_ok));

  // R5: accepted write queues plain status
  a_r5_status_after_write: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_ok && shreg[FW-1]) |=> (resp == 16'h8000));

  // R6: rejected frame queues error status
  a_r6_error_status: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_ok) |=> (resp == 16'h8100));
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.FW(spi_chain_pkg::FW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .spi_miso_oe(spi_miso_oe), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
  .shreg(shreg), .resp(resp), .frame_done(frame_done), .frame_ok(frame_ok), .we(we)
);

// File: tb/sim_spi_chain_slave.sv
module sim_spi_chain_slave;
  localparam int NREGS = 6;
  localparam int H     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe;

  always #2 clk = ~clk;

  spi_chain_slave #(.NREGS(NREGS), .GRAN(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  typedef struct {
    int          n;
    logic [63:0] bits;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails  = 0;
  logic [7:0]  mreg [NREGS];
  logic [15:0] mpend;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: push expected output stream, shift frame, update model
  task automatic xfer(input int n, input logic [63:0] din, input string tag);
    exp_t e;
    logic [15:0] fr;
    e.n = n; e.bits = '0; e.tag = tag;
    for (int i = 0; i < n; i++)
      e.bits = {e.bits[62:0], (i < 16) ? mpend[15-i] : din[n-1-(i-16)]};
    q.push_back(e);
    @(negedge clk);
    cs_n = 1'b0;
    mosi = din[n-1];
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = din[n-1-i];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (12) @(negedge clk);
    fr = din[15:0];
    if ((n % 8 == 0) && (n >= 16)) begin
      if (fr[15]) begin
        if (int'(fr[14:8]) < NREGS) mreg[fr[14:8]] = fr[7:0];
        mpend = 16'h8000;
      end else begin
        mpend = {1'b0, fr[14:8], (int'(fr[14:8]) < NREGS) ? mreg[fr[14:8]] : 8'h00};
      end
    end else begin
      mpend = 16'h8100;
    end
    chk(!miso && !miso_oe, "R1 idle after frame", {62'd0, miso_oe, miso}, 64'd0);
  endtask

  // monitor: collect output bits per transfer and compare with scoreboard
  initial begin
    logic [63:0] got;
    int nb;
    exp_t e;
    forever begin
      @(negedge cs_n);
      got = '0; nb = 0;
      forever begin
        @(posedge sclk or posedge cs_n);
        if (cs_n) break;
        got = {got[62:0], miso};
        nb++;
      end
      if (q.size() == 0) begin
        chk(1'b0, "scoreboard empty", 64'(nb), 64'd0);
      end else begin
        e = q.pop_front();
        chk((nb == e.n) && (got == e.bits), e.tag, got, e.bits);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) mreg[i] = 8'h00;
    mpend = 16'h8000;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!miso && !miso_oe, "R1 reset state", {62'd0, miso_oe, miso}, 64'd0);

    xfer(16, 64'h813C, "R5 write reg1 reply status after reset");
    xfer(16, 64'h85A7, "R3 R5 write reg5 reply status");
    xfer(16, 64'h0100, "R5 read reg1 reply status");
    xfer(16, 64'h0500, "R4 read reg5 reply reg1 data");
    xfer(16, 64'h825A, "R4 write reg2 reply reg5 data");
    xfer(8,  64'h81,   "R6 short 8-bit frame");
    xfer(16, 64'h0200, "R6 error status after short frame");
    xfer(12, 64'h8FF,  "R9 R4 unaligned 12-bit frame reply reg2");
    xfer(20, 64'h081FF, "R6 20-bit frame passes bits");
    xfer(16, 64'h0100, "R6 error status after 20-bit frame");
    xfer(32, 64'h8377_0300, "R7 R2 32-bit chain read reg1 reply, pass-through");
    xfer(24, 64'hAA_8344, "R7 24-bit chain write reg3");
    xfer(16, 64'h0300, "R3 read reg3");
    xfer(16, 64'h8799, "R3 write undefined addr 7 reply reg3");
    xfer(16, 64'h0700, "R8 read undefined addr 7");
    xfer(16, 64'hC111, "R8 write addr 0x41 reply zero data");
    xfer(16, 64'h0100, "R8 read reg1 after alias attempt");
    xfer(16, 64'h0000, "R8 reg1 unchanged by alias write");
    xfer(16, 64'h0000, "R4 read reg0 zero");

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2 scoreboard drained", 64'(q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule